// File: doc/BRIEF.md
# Double-Buffered Frame Base Register with Latch Interrupt

This block keeps the start addresses of the two framebuffer halves, top panel and bottom panel, that a scan-out engine reads from. Software may write a new address for either panel at any moment through a small register port. The write only reaches a pending copy. The scan-out engine keeps reading from a separate active copy, which changes only at a vertical sync.

On every vertical sync strobe, both pending addresses move into the active registers together. A "base latched" status flag is set at the same time, on every frame, whether or not software wrote anything since the last sync. The interrupt line is the status flag gated by an enable bit. Software acknowledges the interrupt by writing ones to a write-one-to-clear register. A driver can queue the next buffer, wait for the latch interrupt, and only then release the buffer that was on screen before.

Top module: `fbase_latch_ctrl`

## Requirements
- R1: The active addresses `upper_base_o`/`lower_base_o` change only on a clock edge where `vsync_i` is 1. At that edge they take the pending values held before the edge. A base write in the same cycle as `vsync_i` changes only the pending copy and shows at the next sync.
- R2: Every clock edge with `vsync_i` high sets raw status bit 0. This happens even when no pending address was written since the previous sync.
- R3: A write to offset 0 changes only the upper pending address. A write to offset 1 changes only the lower pending address.
- R4: `irq_o` equals raw status bit 0 AND enable bit 0. It is visible in the cycle after the edge that changed either of them.
- R5: Writing to offset 7 clears raw status bit 0 when data bit 0 is 1 and leaves it unchanged when bit 0 is 0. Writing back the value read from masked status clears exactly the serviced bit.
- R6: After reset, the pending addresses, active addresses, enable register and status are all zero and `irq_o` is low. Writing 0 to the enable register (offset 4, bit 0) forces `irq_o` low.
- R7: If a sync strobe and a clear of bit 0 fall on the same edge, the status bit ends up set.
- R8: Reads are combinational from `reg_addr`. Offsets 0/1 return the pending upper/lower address, 2/3 the active upper/lower address, 4 the enable register, 5 raw status, 6 masked status, and 7 reads zero. Status and enable occupy bit 0 and all other bits read zero. Writes to offsets 2, 3, 5 and 6 have no effect.
- R9: Bits [1:0] of every written base address are stored as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | ADDR_W | Write data |
| reg_rdata | output | ADDR_W | Read data for `reg_addr` |
| vsync_i | input | 1 | One-cycle vertical sync / frame-start strobe |
| upper_base_o | output | ADDR_W | Active upper panel base address |
| lower_base_o | output | ADDR_W | Active lower panel base address |
| irq_o | output | 1 | Base-latched interrupt |

## Verification
The bench writes a base in the same cycle as a sync. A design that latched the incoming write early would show the new address one frame too soon. It also lets several frames pass with no writes, to catch a design that raises the flag only when an address changed. A sync and a clear on the same edge expose a design that drops a frame event. Writing back the masked status and writing to the read-only offsets expose clears that wipe too much and active registers that software can corrupt.

// File: rtl/fbase_pkg.sv
package fbase_pkg;

  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    OFS_UP_PEND = 3'd0,
    OFS_LO_PEND = 3'd1,
    OFS_UP_ACT  = 3'd2,
    OFS_LO_ACT  = 3'd3,
    OFS_IRQ_EN  = 3'd4,
    OFS_RAW     = 3'd5,
    OFS_MASKED  = 3'd6,
    OFS_CLR     = 3'd7
  } reg_ofs_e;

  // Next value of a sticky status bit: a set always beats a clear.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/fbase_bank.sv
module fbase_bank #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              latch_i,
  output logic [ADDR_W-1:0] pend_o,
  output logic [ADDR_W-1:0] act_o
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));

  function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
    return a & ALIGN_MASK;
  endfunction

  logic [ADDR_W-1:0] pend_q, act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (latch_i) act_q  <= pend_q;
      if (wr_i)    pend_q <= word_align(wdata_i);
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_i |=> $stable(act_o));
  assert_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    latch_i |=> act_o == $past(pend_o));
  assert_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o[ALIGN_BITS-1:0] == '0);

endmodule

// File: rtl/fbase_irq.sv
module fbase_irq
  import fbase_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic en_wr_i,
  input  logic en_bit_i,
  input  logic clr_wr_i,
  input  logic clr_bit_i,
  output logic en_o,
  output logic raw_o,
  output logic masked_o
);

  logic en_q, raw_q;
  logic clr_evt;

  assign clr_evt = clr_wr_i & clr_bit_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      raw_q <= 1'b0;
    end else begin
      if (en_wr_i) en_q <= en_bit_i;
      raw_q <= sticky_next(raw_q, evt_i, clr_evt);
    end
  end

  assign en_o     = en_q;
  assign raw_o    = raw_q;
  assign masked_o = raw_q & en_q;

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> raw_o);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !evt_i) |=> !raw_o);
  assert_setwins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && evt_i) |=> raw_o);
  assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_i && !en_bit_i) |=> !masked_o);
  assert_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && en_o && !(en_wr_i && !en_bit_i)) |=> masked_o);

endmodule

// File: rtl/fbase_rdmux.sv
module fbase_rdmux
  import fbase_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [REG_AW-1:0] addr_i,
  input  logic [ADDR_W-1:0] up_pend_i,
  input  logic [ADDR_W-1:0] lo_pend_i,
  input  logic [ADDR_W-1:0] up_act_i,
  input  logic [ADDR_W-1:0] lo_act_i,
  input  logic              en_i,
  input  logic              raw_i,
  input  logic              masked_i,
  output logic [ADDR_W-1:0] rdata_o
);

  always_comb begin
    unique case (reg_ofs_e'(addr_i))
      OFS_UP_PEND: rdata_o = up_pend_i;
      OFS_LO_PEND: rdata_o = lo_pend_i;
      OFS_UP_ACT:  rdata_o = up_act_i;
      OFS_LO_ACT:  rdata_o = lo_act_i;
      OFS_IRQ_EN:  rdata_o = {{(ADDR_W-1){1'b0}}, en_i};
      OFS_RAW:     rdata_o = {{(ADDR_W-1){1'b0}}, raw_i};
      OFS_MASKED:  rdata_o = {{(ADDR_W-1){1'b0}}, masked_i};
      default:     rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/fbase_latch_ctrl.sv
module fbase_latch_ctrl
  import fbase_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              vsync_i,
  output logic [ADDR_W-1:0] upper_base_o,
  output logic [ADDR_W-1:0] lower_base_o,
  output logic              irq_o
);

  localparam int unsigned NUM_PANELS = 2;

  logic                latch_evt;
  logic [ADDR_W-1:0]   pend [NUM_PANELS];
  logic [ADDR_W-1:0]   act  [NUM_PANELS];
  logic                en_wr, clr_wr;
  logic                en_q, raw_q, masked;

  assign latch_evt = vsync_i;
  assign en_wr     = reg_wr_en && (reg_addr == OFS_IRQ_EN);
  assign clr_wr    = reg_wr_en && (reg_addr == OFS_CLR);

  for (genvar g = 0; g < NUM_PANELS; g++) begin : g_panel
    logic bank_wr;
    assign bank_wr = reg_wr_en && (reg_addr == REG_AW'(g));
    fbase_bank #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (bank_wr),
      .wdata_i (reg_wdata),
      .latch_i (latch_evt),
      .pend_o  (pend[g]),
      .act_o   (act[g])
    );
  end

  fbase_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (latch_evt),
    .en_wr_i   (en_wr),
    .en_bit_i  (reg_wdata[0]),
    .clr_wr_i  (clr_wr),
    .clr_bit_i (reg_wdata[0]),
    .en_o      (en_q),
    .raw_o     (raw_q),
    .masked_o  (masked)
  );

  fbase_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
    .addr_i    (reg_addr),
    .up_pend_i (pend[0]),
    .lo_pend_i (pend[1]),
    .up_act_i  (act[0]),
    .lo_act_i  (act[1]),
    .en_i      (en_q),
    .raw_i     (raw_q),
    .masked_i  (masked),
    .rdata_o   (reg_rdata)
  );

  assign upper_base_o = act[0];
  assign lower_base_o = act[1];
  assign irq_o        = masked;

  assert_ro_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == OFS_UP_ACT && !vsync_i) |=> $stable(upper_base_o));
  assert_ro_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == OFS_LO_ACT && !vsync_i) |=> $stable(lower_base_o));
  assert_sep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == OFS_UP_PEND) |=> $stable(pend[1]));

endmodule

// File: tb/fbase_latch_ctrl_bench.sv
`timescale 1ns/1ps
module fbase_latch_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        vsync = 1'b0;
  logic [31:0] rdata, up, lo;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_pu = 0, m_pl = 0, m_au = 0, m_al = 0;
  logic        m_en = 0, m_raw = 0;

  always #2 clk = ~clk;

  fbase_latch_ctrl u_fbase_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .vsync_i(vsync),
    .upper_base_o(up), .lower_base_o(lo), .irq_o(irq)
  );

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_pu;
      3'd1: return m_pl;
      3'd2: return m_au;
      3'd3: return m_al;
      3'd4: return {31'd0, m_en};
      3'd5: return {31'd0, m_raw};
      3'd6: return {31'd0, m_raw && m_en};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, update model at posedge, release at negedge.
  task automatic tick(input logic w, input logic [2:0] a, input logic [31:0] d, input logic v);
    logic clr;
    wr = w; addr = a; wdata = d; vsync = v;
    @(posedge clk);
    clr = 1'b0;
    if (v) begin m_au = m_pu; m_al = m_pl; end
    if (w) begin
      case (a)
        3'd0: m_pu = {d[31:2], 2'b00};
        3'd1: m_pl = {d[31:2], 2'b00};
        3'd4: m_en = d[0];
        3'd7: clr = d[0];
        default: ;
      endcase
    end
    m_raw = v | (m_raw & ~clr);
    @(negedge clk);
    wr = 1'b0; vsync = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a; #0.5; v = rdata;
  endtask

  task automatic check_outs(input string req);
    check({req, " upper"}, up, m_au);
    check({req, " lower"}, lo, m_al);
    check({req, " irq"}, {31'd0, irq}, {31'd0, m_raw && m_en});
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    logic [31:0] v, up_before;
    void'($urandom(32'h5eed_f00d));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6: reset state
    check_outs("R6 reset");
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); check("R6 reset read", v, 32'd0);
    end

    // R3, R9: independent writes, low bits forced to zero
    tick(1, 3'd0, 32'h1000_0003, 0);
    rd(3'd1, v); check("R3 lower untouched", v, 32'd0);
    rd(3'd0, v); check("R9 aligned upper", v, 32'h1000_0000);
    tick(1, 3'd1, 32'h2000_0006, 0);
    rd(3'd0, v); check("R3 upper untouched", v, 32'h1000_0000);
    rd(3'd1, v); check("R9 aligned lower", v, 32'h2000_0004);
    check_outs("R1 no sync yet");

    // R1: latch on sync; write in sync cycle deferred
    tick(1, 3'd0, 32'h3000_0000, 1);
    check("R1 latched old pending", up, 32'h1000_0000);
    check("R1 lower latched", lo, 32'h2000_0004);
    rd(3'd2, v); check("R8 active read", v, 32'h1000_0000);
    rd(3'd0, v); check("R8 pending read", v, 32'h3000_0000);
    tick(0, 3'd0, 0, 1);
    check("R1 deferred write shows", up, 32'h3000_0000);

    // R4/R6: raw set while disabled, irq low; enable then irq high
    rd(3'd5, v); check("R2 raw set", v, 32'd1);
    check("R6 masked off", {31'd0, irq}, 32'd0);
    tick(1, 3'd4, 32'd1, 0);
    check("R4 irq after enable", {31'd0, irq}, 32'd1);

    // R5: masked write-back, and zero write leaves bit
    tick(1, 3'd7, 32'd0, 0);
    check("R5 zero clear no effect", {31'd0, irq}, 32'd1);
    rd(3'd6, v);
    tick(1, 3'd7, v, 0);
    rd(3'd5, v); check("R5 masked write-back clears", v, 32'd0);
    check("R5 irq low", {31'd0, irq}, 32'd0);

    // R2: frames with no writes still flag
    for (int f = 0; f < 3; f++) begin
      tick(0, 3'd0, 0, 1);
      check("R2 flag without write", {31'd0, irq}, 32'd1);
      tick(1, 3'd7, 32'd1, 0);
      check("R2 cleared between frames", {31'd0, irq}, 32'd0);
    end

    // R7: sync and clear on same edge
    tick(1, 3'd7, 32'hFFFF_FFFF, 1);
    rd(3'd5, v); check("R7 set wins", v, 32'd1);

    // R8: writes to read-only offsets ignored
    up_before = up;
    tick(1, 3'd2, 32'hDEAD_BEE0, 0);
    check("R8 active upper RO", up, up_before);
    tick(1, 3'd3, 32'hDEAD_BEE0, 0);
    check("R8 active lower RO", lo, m_al);
    tick(1, 3'd5, 32'd0, 0);
    tick(1, 3'd6, 32'd0, 0);
    rd(3'd5, v); check("R8 raw RO", v, 32'd1);
    rd(3'd7, v); check("R8 clear reads zero", v, 32'd0);

    // R6: zero enable masks
    tick(1, 3'd4, 32'd0, 0);
    check("R6 zero enable masks", {31'd0, irq}, 32'd0);

    // Random mix
    for (int i = 0; i < 800; i++) begin
      logic [31:0] r;
      r = $urandom;
      tick(r[0] | r[1], 3'($urandom % 8), $urandom, r[4:2] == 3'd0);
      check_outs("R1/R4 random");
      rd(3'($urandom % 8), v);
      check("R8 random read", v, exp_read(addr));
    end

    done = 1;
    summary();
  end

endmodule